// File: doc/BRIEF.md
# NAND Identification Sequencer

This block runs the identification handshake against a NAND flash device from the host side and then classifies the part it finds. A one-cycle start request begins a run. The block drives chip enable, the two latch enables, write enable, read enable and the outgoing I/O byte. It then collects the five identification bytes that the device returns.

Each strobe phase lasts a fixed number of clock cycles, and parameters set those counts. When the fifth byte is in, the sequencer checks the maker code. It then checks the four device bytes against each other and reports density, die count and bus width. If any byte disagrees with the others, it raises an unknown-device flag instead of guessing.

Top module: `nand_id_seq`

## Requirements
- R1: After reset: ce_n_o, we_n_o and re_n_o are 1; cle_o, ale_o, io_oe_o, busy_o and done_o are 0; all classification outputs are 0.
- R2: Each run writes exactly one command byte, 90h, latched on a write-enable rising edge while cle_o is 1. It then writes exactly one address byte, 00h, latched on a write-enable rising edge while ale_o is 1. No other write-enable pulse occurs in the run.
- R3: Each write-enable low phase lasts P_WE_LO cycles and each high phase lasts P_WE_HI cycles. The latch enable of that byte stays 1 through both phases.
- R4: At least P_WHR cycles pass between the last write-enable rising edge and the first read-enable falling edge.
- R5: Exactly five read-enable pulses occur. Each is held low for P_REA cycles, and the bus is sampled on the clock edge that ends the low phase. Each pulse is followed by P_REH cycles high. Read and write enables are never low together.
- R6: id_bytes_o holds the captured bytes in read order, with the first byte in bits [7:0] and the fifth in bits [39:32].
- R7: maker_ok_o is 1 exactly when the first byte is ECh.
- R8: A known device is reported as follows. A second byte of ACh or BCh gives single-die 4Gb (dual_o=0, dens_8g_o=0). A second byte of A3h or B3h gives dual-die 8Gb (dual_o=1, dens_8g_o=1). A second byte of ACh or A3h means an x8 bus (x16_o=0), and BCh or B3h means x16 (x16_o=1).
- R9: unknown_o is 1, and dual_o, dens_8g_o and x16_o are 0, when any of these fails: the maker is ECh; the second byte is one of the four codes; the third byte is 01h for dual and 00h for single; the fourth byte is 55h for x16 and 15h for x8; the fifth byte is 58h for dual and 54h for single.
- R10: done_o is high for exactly one cycle per run, with the classification already valid. busy_o falls on the next cycle. Results hold until the next start.
- R11: A start request while busy_o is 1 is ignored: no extra run and no extra strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request pulse |
| io_i | input | 8 | Byte read from the device bus |
| ce_n_o | output | 1 | Chip enable, active low |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| we_n_o | output | 1 | Write enable, active low |
| re_n_o | output | 1 | Read enable, active low |
| io_o | output | 8 | Byte driven onto the device bus |
| io_oe_o | output | 1 | Output enable for io_o |
| id_bytes_o | output | 40 | Five captured bytes, first byte lowest |
| maker_ok_o | output | 1 | First byte equals ECh |
| unknown_o | output | 1 | Byte combination not recognised |
| dens_8g_o | output | 1 | 8Gb density |
| dual_o | output | 1 | Two dies |
| x16_o | output | 1 | 16-bit bus |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A wrong phase counter or state would show up at the ports within one strobe phase. The pulse widths would be off, a read would start before the write-to-read gap had passed, or the bus would be sampled before the device model presents valid data, so a garbage byte would be captured. A wrong byte index would place bytes in the wrong lanes of id_bytes_o or change the number of read pulses, and this is visible when done_o fires. A decode fault would give wrong class flags on the same done cycle.

// File: rtl/nand_id_pkg.sv
package nand_id_pkg;
  localparam int unsigned ID_LEN = 5;
  localparam logic [7:0] CMD_READ_ID = 8'h90;
  localparam logic [7:0] ADDR_ID     = 8'h00;
  localparam logic [7:0] MAKER_CODE  = 8'hEC;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD_LO, S_CMD_HI, S_ADR_LO, S_ADR_HI,
    S_WHR, S_RD_LO, S_RD_HI, S_DONE
  } seq_state_e;

  typedef struct packed {
    logic maker_ok;
    logic unknown;
    logic dens_8g;
    logic dual;
    logic x16;
  } id_class_t;
endpackage

// File: rtl/nand_id_timer.sv
module nand_id_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= (len_i == '0) ? '0 : len_i - 1'b1;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = (cnt_q == '0);
endmodule

// File: rtl/nand_id_decode.sv
module nand_id_decode
  import nand_id_pkg::*;
(
  input  logic [ID_LEN*8-1:0] bytes_i,
  output id_class_t           cls_o
);
  logic [7:0] b1, b2, b3, b4, b5;
  logic       code_ok, dual, wide, cross_ok, known;

  assign b1 = bytes_i[7:0];
  assign b2 = bytes_i[15:8];
  assign b3 = bytes_i[23:16];
  assign b4 = bytes_i[31:24];
  assign b5 = bytes_i[39:32];

  always_comb begin
    code_ok = 1'b1;
    dual    = 1'b0;
    wide    = 1'b0;
    unique case (b2)
      8'hAC: ;
      8'hBC: wide = 1'b1;
      8'hA3: dual = 1'b1;
      8'hB3: begin dual = 1'b1; wide = 1'b1; end
      default: code_ok = 1'b0;
    endcase
  end

  // remaining bytes must agree with the class implied by the device code
  assign cross_ok = (b3 == (dual ? 8'h01 : 8'h00)) &&
                    (b4 == (wide ? 8'h55 : 8'h15)) &&
                    (b5 == (dual ? 8'h58 : 8'h54));
  assign known    = (b1 == MAKER_CODE) && code_ok && cross_ok;

  assign cls_o.maker_ok = (b1 == MAKER_CODE);
  assign cls_o.unknown  = !known;
  assign cls_o.dens_8g  = known && dual;
  assign cls_o.dual     = known && dual;
  assign cls_o.x16      = known && wide;
endmodule

// File: rtl/nand_id_seq.sv
module nand_id_seq
  import nand_id_pkg::*;
#(
  parameter int unsigned P_WE_LO = 2,
  parameter int unsigned P_WE_HI = 2,
  parameter int unsigned P_WHR   = 6,
  parameter int unsigned P_REA   = 3,
  parameter int unsigned P_REH   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [7:0]          io_i,
  output logic                ce_n_o,
  output logic                cle_o,
  output logic                ale_o,
  output logic                we_n_o,
  output logic                re_n_o,
  output logic [7:0]          io_o,
  output logic                io_oe_o,
  output logic [ID_LEN*8-1:0] id_bytes_o,
  output logic                maker_ok_o,
  output logic                unknown_o,
  output logic                dens_8g_o,
  output logic                dual_o,
  output logic                x16_o,
  output logic                busy_o,
  output logic                done_o
);
  localparam int unsigned MAX_A   = (P_WE_LO > P_WE_HI) ? P_WE_LO : P_WE_HI;
  localparam int unsigned MAX_B   = (P_REA > P_REH) ? P_REA : P_REH;
  localparam int unsigned MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned MAX_LEN = (MAX_C > P_WHR) ? MAX_C : P_WHR;
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);
  localparam int unsigned IDX_W   = $clog2(ID_LEN);

  seq_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q;
  logic [7:0]        byte_q [ID_LEN];
  logic [ID_LEN*8-1:0] bytes_flat;
  logic              load, expire;
  logic [CNT_W-1:0]  len;
  id_class_t         cls_d, cls_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (start_i) state_d = S_CMD_LO;
      S_CMD_LO: if (expire)  state_d = S_CMD_HI;
      S_CMD_HI: if (expire)  state_d = S_ADR_LO;
      S_ADR_LO: if (expire)  state_d = S_ADR_HI;
      S_ADR_HI: if (expire)  state_d = S_WHR;
      S_WHR:    if (expire)  state_d = S_RD_LO;
      S_RD_LO:  if (expire)  state_d = S_RD_HI;
      S_RD_HI:  if (expire)  state_d = (idx_q == IDX_W'(ID_LEN-1)) ? S_DONE : S_RD_LO;
      S_DONE:                state_d = S_IDLE;
      default:               state_d = S_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_d)
      S_CMD_LO, S_ADR_LO: len = CNT_W'(P_WE_LO);
      S_CMD_HI, S_ADR_HI: len = CNT_W'(P_WE_HI);
      S_WHR:              len = CNT_W'(P_WHR);
      S_RD_LO:            len = CNT_W'(P_REA);
      S_RD_HI:            len = CNT_W'(P_REH);
      default:            len = '0;
    endcase
  end

  assign load = (state_d != state_q);

  nand_id_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .len_i   (len),
    .expire_o(expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && start_i)        idx_q <= '0;
      else if (state_q == S_RD_HI && expire)   idx_q <= idx_q + 1'b1;
    end
  end

  for (genvar g = 0; g < ID_LEN; g++) begin : g_cap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) byte_q[g] <= '0;
      else if (state_q == S_RD_LO && expire && idx_q == IDX_W'(g)) byte_q[g] <= io_i;
    end
    assign bytes_flat[g*8 +: 8] = byte_q[g];
  end

  nand_id_decode u_decode (
    .bytes_i(bytes_flat),
    .cls_o  (cls_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   cls_q <= '0;
    else if (state_q == S_RD_HI && state_d == S_DONE) cls_q <= cls_d;
  end

  assign ce_n_o     = (state_q == S_IDLE) || (state_q == S_DONE);
  assign cle_o      = (state_q == S_CMD_LO) || (state_q == S_CMD_HI);
  assign ale_o      = (state_q == S_ADR_LO) || (state_q == S_ADR_HI);
  assign we_n_o     = !((state_q == S_CMD_LO) || (state_q == S_ADR_LO));
  assign re_n_o     = (state_q != S_RD_LO);
  assign io_oe_o    = cle_o || ale_o;
  assign io_o       = cle_o ? CMD_READ_ID : ADDR_ID;
  assign id_bytes_o = bytes_flat;
  assign maker_ok_o = cls_q.maker_ok;
  assign unknown_o  = cls_q.unknown;
  assign dens_8g_o  = cls_q.dens_8g;
  assign dual_o     = cls_q.dual;
  assign x16_o      = cls_q.x16;
  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = (state_q == S_DONE);

  // ---- checks ----
  logic [15:0] gap_q;
  logic        rd_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q     <= '0;
      rd_seen_q <= 1'b0;
    end else begin
      if (!we_n_o)                  gap_q <= '0;
      else if (gap_q != 16'hFFFF)   gap_q <= gap_q + 1'b1;
      if (start_i && !busy_o)       rd_seen_q <= 1'b0;
      else if (!re_n_o)             rd_seen_q <= 1'b1;
    end
  end

  assert_cmd_byte_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(we_n_o) && cle_o) |-> (io_oe_o && io_o == 8'h90));
  assert_addr_byte_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(we_n_o) && ale_o) |-> (io_oe_o && io_o == 8'h00));
  assert_latch_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o));
  assert_whr_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(re_n_o) && !rd_seen_q) |-> (gap_q >= 16'(P_WHR)));
  assert_strobe_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!re_n_o && !we_n_o));
  assert_class_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unknown_o |-> !(dual_o || dens_8g_o || x16_o));
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));
  assert_busy_start_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && start_i) |=> busy_o);
endmodule

// File: tb/nand_id_seq_bench.sv
module nand_id_seq_bench;
  localparam int P_WE_LO = 2, P_WE_HI = 2, P_WHR = 6, P_REA = 3, P_REH = 2;

  logic        clk = 0, rst_n = 0, start = 0;
  logic [7:0]  io_in;
  logic        ce_n, cle, ale, we_n, re_n, io_oe, maker_ok, unknown, dens, dual, x16, busy, done;
  logic [7:0]  io_out;
  logic [39:0] id_bytes;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  nand_id_seq #(.P_WE_LO(P_WE_LO), .P_WE_HI(P_WE_HI), .P_WHR(P_WHR),
                .P_REA(P_REA), .P_REH(P_REH)) u_nand_id_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .io_i(io_in),
    .ce_n_o(ce_n), .cle_o(cle), .ale_o(ale), .we_n_o(we_n), .re_n_o(re_n),
    .io_o(io_out), .io_oe_o(io_oe), .id_bytes_o(id_bytes),
    .maker_ok_o(maker_ok), .unknown_o(unknown), .dens_8g_o(dens), .dual_o(dual),
    .x16_o(x16), .busy_o(busy), .done_o(done));

  // ---- device model, observed at negedge ----
  logic [7:0] dev_id [5];
  int  we_rises, cmd_cnt, adr_cnt, bad_wr, re_pulses, rd_ptr, low_cnt;
  int  cyc, last_we_rise, first_re_fall, we_lo_len, we_hi_len, bad_we_len;
  logic [7:0] cmd_val, adr_val;
  logic we_n_d = 1, re_n_d = 1;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    we_n_d <= we_n;
    re_n_d <= re_n;
    if (!we_n) we_lo_len <= we_lo_len + 1;
    if (we_n && !we_n_d) begin
      we_rises <= we_rises + 1;
      last_we_rise <= cyc;
      if (we_lo_len + 1 != P_WE_LO + 0 && we_lo_len != P_WE_LO) bad_we_len <= bad_we_len + 1;
      we_lo_len <= 0;
      if (cle && io_oe) begin cmd_cnt <= cmd_cnt + 1; cmd_val <= io_out; end
      else if (ale && io_oe) begin adr_cnt <= adr_cnt + 1; adr_val <= io_out; end
      else bad_wr <= bad_wr + 1;
    end
    if (!re_n) low_cnt <= low_cnt + 1; else low_cnt <= 0;
    if (!re_n && re_n_d && first_re_fall < 0) first_re_fall <= cyc;
    if (re_n && !re_n_d) begin re_pulses <= re_pulses + 1; rd_ptr <= rd_ptr + 1; end
  end

  // valid data only once read enable has been low for P_REA cycles
  assign io_in = (!re_n && !ce_n && low_cnt >= P_REA && rd_ptr < 5) ? dev_id[rd_ptr] : 8'hA5;

  task automatic clear_model();
    @(negedge clk);
    we_rises = 0; cmd_cnt = 0; adr_cnt = 0; bad_wr = 0; re_pulses = 0; rd_ptr = 0;
    last_we_rise = 0; first_re_fall = -1; we_lo_len = 0; bad_we_len = 0;
    cmd_val = 8'h00; adr_val = 8'hFF; we_hi_len = 0;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_class(input logic [7:0] b [5]);
    logic d, w, ok, mk;
    mk = (b[0] == 8'hEC);
    ok = 1; d = 0; w = 0;
    case (b[1])
      8'hAC: begin d = 0; w = 0; end
      8'hBC: begin d = 0; w = 1; end
      8'hA3: begin d = 1; w = 0; end
      8'hB3: begin d = 1; w = 1; end
      default: ok = 0;
    endcase
    if (b[2] != (d ? 8'h01 : 8'h00)) ok = 0;
    if (b[3] != (w ? 8'h55 : 8'h15)) ok = 0;
    if (b[4] != (d ? 8'h58 : 8'h54)) ok = 0;
    ok = ok && mk;
    // {maker_ok, unknown, dens, dual, x16}
    return {mk, !ok, ok && d, ok && d, ok && w};
  endfunction

  task automatic run_id(input logic [7:0] b [5], input bit poke_busy);
    logic [39:0] exp_bytes;
    logic [4:0]  ec;
    int t;
    bit got;
    clear_model();
    for (int i = 0; i < 5; i++) dev_id[i] = b[i];
    start = 1;
    @(negedge clk);
    start = 0;
    got = 0;
    for (t = 0; t < 500; t++) begin
      if (poke_busy && t == 20) start = 1;
      if (poke_busy && t == 21) start = 0;
      if (done) begin got = 1; break; end
      @(negedge clk);
    end
    chk(got, "R10", "done seen", 64'(got), 64'd1);
    for (int i = 0; i < 5; i++) exp_bytes[i*8 +: 8] = b[i];
    ec = exp_class(b);
    chk(id_bytes == exp_bytes, "R6", "id bytes", 64'(id_bytes), 64'(exp_bytes));
    chk(maker_ok == ec[4], "R7", "maker_ok", 64'(maker_ok), 64'(ec[4]));
    chk(unknown == ec[3], "R9", "unknown", 64'(unknown), 64'(ec[3]));
    chk({dens, dual, x16} == ec[2:0], "R8", "class", 64'({dens, dual, x16}), 64'(ec[2:0]));
    chk(cmd_cnt == 1 && cmd_val == 8'h90, "R2", "cmd", 64'({cmd_cnt[7:0], cmd_val}), 64'h0190);
    chk(adr_cnt == 1 && adr_val == 8'h00 && bad_wr == 0, "R2", "addr",
        64'({adr_cnt[7:0], adr_val, bad_wr[7:0]}), 64'h010000);
    chk(re_pulses == 5, "R5", "read pulses", 64'(re_pulses), 64'd5);
    chk(first_re_fall - last_we_rise >= P_WHR, "R4", "whr gap",
        64'(first_re_fall - last_we_rise), 64'(P_WHR));
    @(negedge clk);
    chk(!done && !busy, "R10", "done one cycle", 64'({done, busy}), 64'd0);
    repeat (8) @(negedge clk);
    chk(!busy && we_rises == 2 && id_bytes == exp_bytes, "R11", "no extra run / results hold",
        64'({busy, we_rises[7:0]}), 64'h002);
  endtask

  // watchdog
  initial begin
    #(200000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // R3 strobe width check at the ports
  int wl = 0, wh = 0;
  bit in_run = 0;
  always @(negedge clk) begin
    if (!rst_n) begin wl <= 0; wh <= 0; end
    else begin
      if (!we_n) wl <= wl + 1;
      else if (we_n_d == 0) begin
        checks++;
        if (wl != P_WE_LO) begin errors++; $display("FAIL R3 we low width: actual %0d expected %0d", wl, P_WE_LO); end
        wl <= 0;
      end
      if (!re_n) wh <= wh + 1;
      else if (re_n_d == 0) begin
        checks++;
        if (wh != P_REA) begin errors++; $display("FAIL R5 re low width: actual %0d expected %0d", wh, P_REA); end
        wh <= 0;
      end
    end
  end

  initial begin
    logic [7:0] b [5];
    int unused;
    unused = $urandom(32'd1234);
    cyc = 0;
    repeat (3) @(negedge clk);
    chk(ce_n && we_n && re_n && !cle && !ale && !io_oe && !busy && !done &&
        !maker_ok && !unknown && !dens && !dual && !x16, "R1", "reset state",
        64'({ce_n, we_n, re_n, cle, ale, io_oe, busy, done}), 64'hE0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // directed: the four known parts
    b = '{8'hEC, 8'hAC, 8'h00, 8'h15, 8'h54}; run_id(b, 0);
    b = '{8'hEC, 8'hA3, 8'h01, 8'h15, 8'h58}; run_id(b, 0);
    b = '{8'hEC, 8'hBC, 8'h00, 8'h55, 8'h54}; run_id(b, 1);
    b = '{8'hEC, 8'hB3, 8'h01, 8'h55, 8'h58}; run_id(b, 0);
    // corners: wrong maker, inconsistent die byte, bad width byte
    b = '{8'h98, 8'hAC, 8'h00, 8'h15, 8'h54}; run_id(b, 0);
    b = '{8'hEC, 8'hAC, 8'h01, 8'h15, 8'h54}; run_id(b, 0);
    b = '{8'hEC, 8'hB3, 8'h01, 8'h15, 8'h58}; run_id(b, 1);
    b = '{8'hEC, 8'hA3, 8'h01, 8'h15, 8'h54}; run_id(b, 0);

    // random: legal parts with occasional single-byte corruption
    for (int n = 0; n < 30; n++) begin
      int k;
      k = $urandom_range(0, 3);
      b[0] = 8'hEC;
      b[1] = (k == 0) ? 8'hAC : (k == 1) ? 8'hA3 : (k == 2) ? 8'hBC : 8'hB3;
      b[2] = (k[0]) ? 8'h01 : 8'h00;
      b[3] = (k[1]) ? 8'h55 : 8'h15;
      b[4] = (k[0]) ? 8'h58 : 8'h54;
      if ($urandom_range(0, 2) == 0) b[$urandom_range(0, 4)] = 8'($urandom);
      run_id(b, $urandom_range(0, 1) == 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule